// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt requests for an 8-bit microcontroller core from eight sources. Three are external pins, three are timers, one is a serial port and one is an HDLC engine. Each cycle it picks the request that should be served, and it presents that request to the core as a request strobe with an 8-bit vector address. Four small registers sit behind a plain register write/read port: source enables with a global gate, a per-source priority level, a polarity per external pin, and the edge/level choice for the first two pins.

The core-facing pair `irq_req`/`irq_ack` works as a valid/ready handshake. `irq_req` stays high as long as an eligible request exists. While it is unacknowledged, `irq_vec` may move to a better candidate. The core takes the vector shown in the cycle where it raises `irq_ack`. An acknowledge while `irq_req` is low is dropped. An accepted request marks its priority level as in service. A high-level request may interrupt a low-level handler. `irq_reti` releases one level per pulse, the high level first. When acknowledge and return land in the same cycle, the return is applied first.

The external pins pass through a synchronizer and are assumed idle high while reset is active. Timer, serial and HDLC requests are levels owned by their peripherals. The HDLC source is masked only by its own enable input.

Top module: `vic2l_top`

## Requirements
- R1: Register port: address A8h holds the enable byte, B8h the priority byte, A9h the polarity bits (bits 2:0, bit n for pin n) and 88h the trigger bits (bit 1 for pin 0, bit 3 for pin 1). All reset to 0 and read back combinationally. Unimplemented bits read 0. Other addresses read 00h and ignore writes.
- R2: Source slot i (0 pin 0, 1 timer 0, 2 pin 1, 3 timer 1, 4 serial, 5 timer 2, 6 pin 2, 7 HDLC) is presented as vector 8*i+3. `irq_vec` is 00h whenever `irq_req` is low.
- R3: With enable bit 7 at 0, `irq_req` stays low.
- R4: Enable bit i (i = 0..6) masks slot i. Slot 7 is masked only by `hdlc_en`.
- R5: Among eligible requests at the same level, the lowest slot number wins.
- R6: Priority bit i at 1 puts slot i on the high level. A high-level request beats any low-level request.
- R7: With nothing in service, any eligible request is presented. With the low level in service, only high-level requests are presented. With the high level in service, none is presented.
- R8: An `irq_reti` pulse clears the high in-service bit if it is set, otherwise the low one.
- R9: Polarity bit n at 0 makes pin n active low; at 1, active high. A pin change reaches a level request after the second rising clock edge and sets an edge flag on the third.
- R10: Pins 0 and 1 with trigger bit 0 request for as long as the synchronized pin is active. An acknowledge does not clear this.
- R11: Pins 0 and 1 with trigger bit 1, and pin 2 always, latch a flag on an inactive-to-active transition. The flag holds after the pin returns and clears when that slot is acknowledged.
- R12: Timer, serial and HDLC inputs are not cleared on acknowledge. They request again once their level leaves service.
- R13: `irq_ack` with `irq_req` low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ext_pin | input | 3 | External interrupt pins 2..0 |
| tmr0_req | input | 1 | Timer 0 request level |
| tmr1_req | input | 1 | Timer 1 request level |
| tmr2_req | input | 1 | Timer 2 request level |
| ser_req | input | 1 | Serial port request level |
| hdlc_req | input | 1 | HDLC request level |
| hdlc_en | input | 1 | HDLC mask (1 = enabled) |
| irq_req | output | 1 | Request to core (valid) |
| irq_vec | output | 8 | Vector address of presented request |
| irq_ack | input | 1 | Core accepts presented request (ready) |
| irq_reti | input | 1 | Return-from-interrupt pulse |

## Verification
Several results are due at different times. Peripheral levels reach `irq_req`/`irq_vec` in the same cycle. Register writes, acknowledges and returns show after the edge that samples them. A pin level shows after the second edge and a pin edge after the third. The bench changes inputs half a nanosecond after the falling edge and compares against a behavioural model at every falling edge. Directed checks are taken just before the next input change, with the number of edges counted explicitly for each case.

// File: rtl/vic2l_pkg.sv
package vic2l_pkg;
  localparam int NSRC       = 8;
  localparam int IDX_W      = $clog2(NSRC);
  localparam int NEXT       = 3;
  localparam int REG_W      = 8;
  localparam int VEC_STRIDE = 8;
  localparam int VEC_OFFSET = 3;

  localparam logic [REG_W-1:0] A_ENABLE = 8'hA8;
  localparam logic [REG_W-1:0] A_PRIO   = 8'hB8;
  localparam logic [REG_W-1:0] A_POLAR  = 8'hA9;
  localparam logic [REG_W-1:0] A_TRIG   = 8'h88;

  typedef logic [IDX_W-1:0] src_idx_t;

  typedef struct packed {
    logic     hit;
    src_idx_t idx;
  } pick_t;

  // lowest set bit wins: fixed polling order
  function automatic pick_t pick_first(input logic [NSRC-1:0] v);
    pick_t p;
    p = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.hit = 1'b1;
        p.idx = src_idx_t'(i);
      end
    end
    return p;
  endfunction

  function automatic logic [REG_W-1:0] vector_of(input src_idx_t i);
    return REG_W'(int'(i) * VEC_STRIDE + VEC_OFFSET);
  endfunction

  // slot number of external pin g
  function automatic src_idx_t ext_slot(input int g);
    case (g)
      0:       return src_idx_t'(0);
      1:       return src_idx_t'(2);
      default: return src_idx_t'(6);
    endcase
  endfunction
endpackage

// File: rtl/vic2l_regs.sv
module vic2l_regs
  import vic2l_pkg::*;
#(
  parameter int NPIN = NEXT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] pri_q,
  output logic [NPIN-1:0]  pol_q,
  output logic [1:0]       trig_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pri_q  <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (wr) begin
      case (addr)
        A_ENABLE: en_q   <= wdata;
        A_PRIO:   pri_q  <= wdata;
        A_POLAR:  pol_q  <= wdata[NPIN-1:0];
        A_TRIG:   trig_q <= {wdata[3], wdata[1]};
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_ENABLE: rdata = en_q;
      A_PRIO:   rdata = pri_q;
      A_POLAR:  rdata[NPIN-1:0] = pol_q;
      A_TRIG:   begin
        rdata[1] = trig_q[0];
        rdata[3] = trig_q[1];
      end
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/vic2l_pin.sv
module vic2l_pin #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   act;
  logic                   prev_q;
  logic                   flag_q;
  logic                   rise;

  // pins idle high during reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  assign act  = pol ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];
  assign rise = act & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= act;
      if (!edge_mode) flag_q <= 1'b0;
      else if (rise)  flag_q <= 1'b1;
      else if (clr)   flag_q <= 1'b0;
    end
  end

  assign req = edge_mode ? flag_q : act;
endmodule

// File: rtl/vic2l_arb.sv
module vic2l_arb
  import vic2l_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  mask,
  input  logic [NSRC-1:0]  prio,
  input  logic             gen,
  input  logic             ack,
  input  logic             reti,
  output logic             req,
  output logic [REG_W-1:0] vec,
  output src_idx_t         sel,
  output logic             grant,
  output logic [1:0]       ins
);
  logic [NSRC-1:0] elig, hi_c, lo_c;
  pick_t           pk_hi, pk_lo;
  logic            take_hi, take_lo;
  logic            ins_hi_q, ins_lo_q;
  logic            ins_hi_d, ins_lo_d;

  assign elig  = pend & mask & {NSRC{gen}};
  assign hi_c  = elig & prio;
  assign lo_c  = elig & ~prio;
  assign pk_hi = pick_first(hi_c);
  assign pk_lo = pick_first(lo_c);

  assign take_hi = pk_hi.hit & ~ins_hi_q;
  assign take_lo = ~take_hi & pk_lo.hit & ~ins_hi_q & ~ins_lo_q;

  assign req   = take_hi | take_lo;
  assign sel   = take_hi ? pk_hi.idx : pk_lo.idx;
  assign vec   = req ? vector_of(sel) : '0;
  assign grant = ack & req;

  always_comb begin
    ins_hi_d = ins_hi_q;
    ins_lo_d = ins_lo_q;
    if (reti) begin
      if (ins_hi_q) ins_hi_d = 1'b0;
      else          ins_lo_d = 1'b0;
    end
    if (grant) begin
      if (take_hi) ins_hi_d = 1'b1;
      else         ins_lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_hi_q <= 1'b0;
      ins_lo_q <= 1'b0;
    end else begin
      ins_hi_q <= ins_hi_d;
      ins_lo_q <= ins_lo_d;
    end
  end

  assign ins = {ins_hi_q, ins_lo_q};
endmodule

// File: rtl/vic2l_top.sv
module vic2l_top
  import vic2l_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NEXT-1:0]  ext_pin,
  input  logic             tmr0_req,
  input  logic             tmr1_req,
  input  logic             tmr2_req,
  input  logic             ser_req,
  input  logic             hdlc_req,
  input  logic             hdlc_en,
  output logic             irq_req,
  output logic [REG_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic             irq_reti
);
  logic [REG_W-1:0] en_q, pri_q;
  logic [NEXT-1:0]  pol_q;
  logic [1:0]       trig_q;
  logic [NEXT-1:0]  x_req, x_edge, x_clr;
  logic [NSRC-1:0]  pend, mask;
  src_idx_t         sel;
  logic             grant;
  logic [1:0]       ins_lvl;

  vic2l_regs #(.NPIN(NEXT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en_q(en_q),
    .pri_q(pri_q), .pol_q(pol_q), .trig_q(trig_q)
  );

  for (genvar g = 0; g < NEXT; g++) begin : g_pin
    if (g < 2) begin : g_sel
      assign x_edge[g] = trig_q[g];
    end else begin : g_fixed
      assign x_edge[g] = 1'b1;
    end
    assign x_clr[g] = grant && (sel == ext_slot(g));
    vic2l_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin[g]), .pol(pol_q[g]),
      .edge_mode(x_edge[g]), .clr(x_clr[g]), .req(x_req[g])
    );
  end

  assign pend = {hdlc_req, x_req[2], tmr2_req, ser_req,
                 tmr1_req, x_req[1], tmr0_req, x_req[0]};
  assign mask = {hdlc_en, en_q[NSRC-2:0]};

  vic2l_arb u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .prio(pri_q),
    .gen(en_q[REG_W-1]), .ack(irq_ack), .reti(irq_reti), .req(irq_req),
    .vec(irq_vec), .sel(sel), .grant(grant), .ins(ins_lvl)
  );
endmodule

// File: rtl/vic2l_chk.sv
module vic2l_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic [7:0] irq_vec,
  input logic       irq_ack,
  input logic       irq_reti,
  input logic       gen,
  input logic [1:0] ins
);
  // R3
  gen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gen);
  // R2
  vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3));
  // R2
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == 8'h00));
  // R7
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins[1] |-> !irq_req);
  // R7
  ack_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (ins != 2'b00));
  // R8
  reti_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && !irq_ack && ins[1]) |=> (!ins[1] && ins[0] == $past(ins[0])));
  // R13
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !irq_reti) |=> (ins == $past(ins)));
endmodule

bind vic2l_top vic2l_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
  .irq_ack(irq_ack), .irq_reti(irq_reti), .gen(en_q[7]), .ins(ins_lvl)
);

// File: tb/vic2l_top_tb.sv
`timescale 1ns/1ps
module vic2l_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [2:0] ext_pin = 3'b111;
  logic       tmr0_req = 0, tmr1_req = 0, tmr2_req = 0, ser_req = 0;
  logic       hdlc_req = 0, hdlc_en = 0;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic       irq_ack = 0, irq_reti = 0;

  int  n_chk = 0, n_fail = 0;
  bit  run_chk = 0, done = 0;

  always #2 clk = ~clk;

  vic2l_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .tmr0_req(tmr0_req), .tmr1_req(tmr1_req), .tmr2_req(tmr2_req),
    .ser_req(ser_req), .hdlc_req(hdlc_req), .hdlc_en(hdlc_en),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_reti(irq_reti)
  );

  // ---------------- behavioural reference model ----------------
  bit [7:0] m_en, m_pri;
  bit [2:0] m_pol, m_s1, m_s2, m_prev, m_flag;
  bit [1:0] m_trig;
  bit       m_ihi, m_ilo;

  function automatic bit m_act(int n);
    return m_pol[n] ? m_s2[n] : !m_s2[n];
  endfunction

  function automatic bit m_is_edge(int n);
    return (n == 2) || m_trig[n];
  endfunction

  function automatic bit m_xreq(int n);
    return m_is_edge(n) ? m_flag[n] : m_act(n);
  endfunction

  // returns slot + 8*level, or -1 when nothing is presented
  function automatic int m_pick();
    bit p [8];
    bit e;
    p[0] = m_xreq(0); p[1] = tmr0_req; p[2] = m_xreq(1); p[3] = tmr1_req;
    p[4] = ser_req;   p[5] = tmr2_req; p[6] = m_xreq(2); p[7] = hdlc_req;
    for (int lv = 1; lv >= 0; lv--) begin
      if (lv == 1 && m_ihi) continue;
      if (lv == 0 && (m_ihi || m_ilo)) continue;
      for (int i = 0; i < 8; i++) begin
        e = p[i] && m_en[7] && ((i == 7) ? hdlc_en : m_en[i]);
        if (e && (m_pri[i] == lv[0])) return i + 8 * lv;
      end
    end
    return -1;
  endfunction

  function automatic bit [7:0] m_rdata();
    case (reg_addr)
      8'hA8: return m_en;
      8'hB8: return m_pri;
      8'hA9: return {5'b0, m_pol};
      8'h88: return {4'b0, m_trig[1], 1'b0, m_trig[0], 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic int slot_of_pin(int n);
    return (n == 0) ? 0 : (n == 1) ? 2 : 6;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pri = 0; m_pol = 0; m_trig = 0;
      m_s1 = 3'b111; m_s2 = 3'b111; m_prev = 0; m_flag = 0;
      m_ihi = 0; m_ilo = 0;
    end else begin
      int  pk;
      bit  fire;
      bit  a;
      pk   = m_pick();
      fire = irq_ack && (pk >= 0);
      for (int n = 0; n < 3; n++) begin
        a = m_act(n);
        if (!m_is_edge(n)) m_flag[n] = 0;
        else if (a && !m_prev[n]) m_flag[n] = 1;
        else if (fire && (pk % 8) == slot_of_pin(n)) m_flag[n] = 0;
        m_prev[n] = a;
      end
      m_s2 = m_s1;
      m_s1 = ext_pin;
      if (irq_reti) begin
        if (m_ihi) m_ihi = 0;
        else       m_ilo = 0;
      end
      if (fire) begin
        if (pk >= 8) m_ihi = 1;
        else         m_ilo = 1;
      end
      if (reg_wr) begin
        case (reg_addr)
          8'hA8: m_en = reg_wdata;
          8'hB8: m_pri = reg_wdata;
          8'hA9: m_pol = reg_wdata[2:0];
          8'h88: m_trig = {reg_wdata[3], reg_wdata[1]};
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (run_chk && !done) begin
      int pk;
      bit [7:0] ev;
      pk = m_pick();
      ev = (pk >= 0) ? 8'((pk % 8) * 8 + 3) : 8'h00;
      chk(irq_req == (pk >= 0), "R7 irq_req vs model", irq_req, (pk >= 0));
      chk(irq_vec == ev, "R2 irq_vec vs model", irq_vec, ev);
      chk(reg_rdata == m_rdata(), "R1 reg_rdata vs model", reg_rdata, m_rdata());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    #0.5;
    chk(reg_rdata == e, tag, reg_rdata, e);
  endtask

  task automatic out_chk(input bit er, input logic [7:0] ev, input string tag);
    #0.2;
    chk(irq_req == er, tag, irq_req, er);
    if (er) chk(irq_vec == ev, tag, irq_vec, ev);
  endtask

  task automatic pulse_ack();
    irq_ack = 1; tick(); irq_ack = 0;
  endtask

  task automatic pulse_reti();
    irq_reti = 1; tick(); irq_reti = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    rst_n = 1;
    run_chk = 1;
    // reset state
    out_chk(0, 8'h00, "R2 reset no request");
    rd_chk(8'hA8, 8'h00, "R1 enable reset");
    rd_chk(8'hB8, 8'h00, "R1 priority reset");
    // register port
    wr(8'hA9, 8'hFA); rd_chk(8'hA9, 8'h02, "R1 polarity bits");
    wr(8'h88, 8'hFF); rd_chk(8'h88, 8'h0A, "R1 trigger bits");
    wr(8'h10, 8'h55); rd_chk(8'h10, 8'h00, "R1 unmapped address");
    wr(8'hA9, 8'h00); wr(8'h88, 8'h00);
    // global gate and per-slot enable
    tmr0_req = 1;
    wr(8'hA8, 8'h02); out_chk(0, 8'h00, "R3 global gate off");
    wr(8'hA8, 8'h82); out_chk(1, 8'h0B, "R4 timer0 enabled");
    tmr0_req = 0; hdlc_req = 1;
    wr(8'hA8, 8'hFF); out_chk(0, 8'h00, "R4 hdlc masked by hdlc_en");
    hdlc_en = 1; out_chk(1, 8'h3B, "R4 hdlc enabled");
    // fixed order within a level
    tmr1_req = 1; ser_req = 1; out_chk(1, 8'h1B, "R5 timer1 first");
    tmr1_req = 0; out_chk(1, 8'h23, "R5 serial next");
    // priority level
    wr(8'hB8, 8'h80); out_chk(1, 8'h3B, "R6 high level hdlc wins");
    wr(8'hB8, 8'h00);
    // acknowledge when idle
    hdlc_req = 0; ser_req = 0; out_chk(0, 8'h00, "R7 idle");
    pulse_ack();
    ser_req = 1; out_chk(1, 8'h23, "R13 idle ack ignored");
    // nesting
    pulse_ack(); out_chk(0, 8'h00, "R12 serial held but low in service");
    tmr1_req = 1; out_chk(0, 8'h00, "R7 no same-level preempt");
    wr(8'hB8, 8'h08); out_chk(1, 8'h1B, "R7 high preempts low");
    pulse_ack(); out_chk(0, 8'h00, "R7 high in service blocks all");
    pulse_reti(); out_chk(1, 8'h1B, "R8 high released first");
    tmr1_req = 0; out_chk(0, 8'h00, "R8 low still in service");
    pulse_reti(); out_chk(1, 8'h23, "R8 low released");
    ser_req = 0;
    wr(8'hB8, 8'h00);
    // pin 0 level mode
    wr(8'hA8, 8'h81);
    ext_pin[0] = 0; tick(); out_chk(0, 8'h00, "R9 one edge not yet");
    tick(); out_chk(1, 8'h03, "R9 level after second edge");
    pulse_ack(); out_chk(0, 8'h00, "R10 in service");
    pulse_reti(); out_chk(1, 8'h03, "R10 level not cleared by ack");
    ext_pin[0] = 1; tick(); out_chk(1, 8'h03, "R9 release delayed");
    tick(); out_chk(0, 8'h00, "R10 follows pin");
    // pin 0 edge mode
    wr(8'h88, 8'h02);
    ext_pin[0] = 0; tick(); tick(); out_chk(0, 8'h00, "R9 edge not yet");
    tick(); out_chk(1, 8'h03, "R11 edge flag after third edge");
    ext_pin[0] = 1; tick(); tick(); tick(); out_chk(1, 8'h03, "R11 flag held");
    pulse_ack(); pulse_reti(); out_chk(0, 8'h00, "R11 flag cleared on ack");
    // pin 2 falling then rising
    wr(8'hA8, 8'hC0);
    ext_pin[2] = 0; tick(); tick(); tick(); out_chk(1, 8'h33, "R11 pin2 falling edge");
    pulse_ack(); pulse_reti(); out_chk(0, 8'h00, "R11 pin2 flag cleared");
    wr(8'hA9, 8'h04);
    ext_pin[2] = 1; tick(); tick(); out_chk(0, 8'h00, "R9 pin2 rising not yet");
    tick(); out_chk(1, 8'h33, "R9 pin2 rising edge with polarity 1");
    ext_pin[2] = 0; tick(); tick(); tick(); out_chk(1, 8'h33, "R11 pin2 flag held");
    pulse_ack(); pulse_reti(); out_chk(0, 8'h00, "R11 pin2 cleared again");
    // pin 1 active-high level
    wr(8'hA8, 8'h84);
    out_chk(0, 8'h00, "R9 pin1 inactive with polarity 0");
    wr(8'hA9, 8'h06); out_chk(1, 8'h13, "R9 pin1 active high");
    tick(); tick();
    done = 1;
    summary();
    $finish;
  end
endmodule